// File: doc/BRIEF.md
# Fast A20 Gate Command Decoder

This block drives the A20 address gate without help from firmware. It watches host writes to channel 1 of the host data port. A write that carries the command flag and the byte 0xD1 arms the decoder. If the next qualifying write is a data byte, bit 1 of that byte becomes the new gate level. The decoder then returns to idle, and another 0xD1 is needed before the gate can change again.

A single enable bit switches the hardware path on or off. While it is off, the decoder is held idle and the gate keeps its last level. A second output copies the gate level so that software can read it through a status bit.

The data width, the arming command code, the data bit that is copied and the reset level are all parameters. A further parameter can add a register stage on the host write, at the cost of one cycle of latency.

Top module: `fast_a20_gate`

## Requirements
- R1: After reset the gate output is 1 and the decoder is idle, so a data write that follows reset does not change the gate.
- R2: A channel-1 write with the command flag set (`host_is_cmd` = 1) and the byte 0xD1, made while enabled, arms the decoder.
- R3: A channel-1 data write (`host_is_cmd` = 0) made while the decoder is armed loads bit 1 of the written byte into the gate output.
- R4: After the data byte of R3 has been applied the decoder is idle, so a second data write leaves the gate unchanged.
- R5: A channel-1 command write with any byte other than 0xD1, made while armed, cancels the armed state and leaves the gate unchanged.
- R6: While `fast_en` is 0, host writes have no effect, the decoder is forced idle and the gate holds its value.
- R7: A write made while `host_cs1` is 0 has no effect on the gate or on the armed state.
- R8: A channel-1 data write made while the decoder is idle leaves the gate unchanged.
- R9: `gate_level` always equals `gate_out`.
- R10: A 0xD1 command received while already armed keeps the decoder armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_en | input | 1 | Enable for the hardware gate path |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_cs1 | input | 1 | The write targets channel 1 |
| host_is_cmd | input | 1 | 1 = command byte, 0 = data byte |
| host_byte | input | DATA_W | Byte written by the host |
| gate_out | output | 1 | A20 gate pin level |
| gate_level | output | 1 | Readable copy of the gate level |

## Verification
With the default configuration (no input register), the effect of a write on the gate appears at the rising edge that samples the write. Arming and cancelling are recorded at that same edge. The bench drives each write on a falling edge, updates its own model at the following rising edge, and compares `gate_out` and `gate_level` on the next falling edge. Every check therefore falls one half period after the edge that should have produced the result. The armed state cannot be seen at the ports, so the bench observes it through the gate response to the data write that follows.

// File: rtl/fast_a20_pkg.sv
package fast_a20_pkg;

   typedef enum logic [0:0] {
      DEC_IDLE  = 1'b0,
      DEC_ARMED = 1'b1
   } a20_dec_state_t;

   typedef struct packed {
      logic cmd_arm;    // qualified arming command
      logic cmd_other;  // qualified command, any other code
      logic data;       // qualified data write
   } a20_wr_kind_t;

   localparam a20_wr_kind_t A20_WR_NONE = '{cmd_arm: 1'b0, cmd_other: 1'b0, data: 1'b0};

endpackage

// File: rtl/a20_wr_qual.sv
module a20_wr_qual
   import fast_a20_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter logic [7:0]  CMD_CODE  = 8'hD1,
   parameter int unsigned GATE_BIT  = 1,
   parameter bit          REG_INPUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wr,
   input  logic              cs,
   input  logic              is_cmd,
   input  logic [DATA_W-1:0] wr_byte,
   output a20_wr_kind_t      kind,
   output logic              gate_bit
);

   localparam int unsigned CODE_W = (DATA_W < 8) ? DATA_W : 8;

   initial begin
      if (GATE_BIT >= DATA_W)
         $error("a20_wr_qual: GATE_BIT %0d outside DATA_W %0d", GATE_BIT, DATA_W);
      if (DATA_W < 2)
         $error("a20_wr_qual: DATA_W must be at least 2");
   end

   logic         hit;
   logic         code_match;
   a20_wr_kind_t kind_c;

   assign hit        = en & wr & cs;
   assign code_match = (wr_byte[CODE_W-1:0] == CMD_CODE[CODE_W-1:0]);

   always_comb begin
      kind_c           = A20_WR_NONE;
      kind_c.cmd_arm   = hit &  is_cmd &  code_match;
      kind_c.cmd_other = hit &  is_cmd & ~code_match;
      kind_c.data      = hit & ~is_cmd;
   end

   generate
      if (REG_INPUT) begin : g_reg
         a20_wr_kind_t kind_q;
         logic         bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               kind_q <= A20_WR_NONE;
               bit_q  <= 1'b0;
            end else begin
               kind_q <= kind_c;
               bit_q  <= wr_byte[GATE_BIT];
            end
         end
         assign kind     = kind_q;
         assign gate_bit = bit_q;
      end else begin : g_comb
         assign kind     = kind_c;
         assign gate_bit = wr_byte[GATE_BIT];
      end
   endgenerate

   // At most one kind of write is reported per cycle.
   AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({kind.cmd_arm, kind.cmd_other, kind.data})) else $error("kind overlap"); // R2

endmodule

// File: rtl/a20_cmd_fsm.sv
module a20_cmd_fsm
   import fast_a20_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  a20_wr_kind_t kind,
   output logic         apply
);

   a20_dec_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (!en) begin
         state_d = DEC_IDLE;
      end else if (kind.cmd_arm) begin
         state_d = DEC_ARMED;
      end else if (kind.cmd_other || kind.data) begin
         state_d = DEC_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= DEC_IDLE;
      else        state_q <= state_d;
   end

   assign apply = en & kind.data & (state_q == DEC_ARMED);

   AST_ARM_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (en && kind.cmd_arm) |=> (state_q == DEC_ARMED)) else $error("arm missed"); // R2
   AST_IDLE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == DEC_ARMED && kind.data) |=> (state_q == DEC_IDLE)) else $error("stayed armed"); // R4
   AST_CANCEL_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
      kind.cmd_other |=> (state_q == DEC_IDLE)) else $error("cancel missed"); // R5
   AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (state_q == DEC_IDLE)) else $error("armed while off"); // R6
   AST_REARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == DEC_ARMED && en && kind.cmd_arm) |=> (state_q == DEC_ARMED)) else $error("rearm lost"); // R10

endmodule

// File: rtl/a20_gate_reg.sv
module a20_gate_reg #(
   parameter bit RESET_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic apply,
   input  logic new_level,
   output logic gate
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     gate <= RESET_LEVEL;
      else if (apply) gate <= new_level;
   end

   AST_LOAD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      apply |=> (gate == $past(new_level))) else $error("load wrong"); // R3
   AST_HOLD_NO_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
      !apply |=> $stable(gate)) else $error("gate moved"); // R8

endmodule

// File: rtl/fast_a20_gate.sv
module fast_a20_gate
   import fast_a20_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter logic [7:0]  CMD_CODE    = 8'hD1,
   parameter int unsigned GATE_BIT    = 1,
   parameter bit          RESET_LEVEL = 1'b1,
   parameter bit          REG_INPUT   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fast_en,
   input  logic              host_wr,
   input  logic              host_cs1,
   input  logic              host_is_cmd,
   input  logic [DATA_W-1:0] host_byte,
   output logic              gate_out,
   output logic              gate_level
);

   a20_wr_kind_t kind;
   logic         gate_bit;
   logic         apply;
   logic         gate_q;

   a20_wr_qual #(
      .DATA_W   (DATA_W),
      .CMD_CODE (CMD_CODE),
      .GATE_BIT (GATE_BIT),
      .REG_INPUT(REG_INPUT)
   ) i_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (fast_en),
      .wr      (host_wr),
      .cs      (host_cs1),
      .is_cmd  (host_is_cmd),
      .wr_byte (host_byte),
      .kind    (kind),
      .gate_bit(gate_bit)
   );

   a20_cmd_fsm i_fsm (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (fast_en),
      .kind (kind),
      .apply(apply)
   );

   a20_gate_reg #(
      .RESET_LEVEL(RESET_LEVEL)
   ) i_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .apply    (apply),
      .new_level(gate_bit),
      .gate     (gate_q)
   );

   assign gate_out   = gate_q;
   assign gate_level = gate_q;

   AST_OFF_HOLDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !fast_en |=> $stable(gate_out)) else $error("gate moved while off"); // R6
   AST_NO_CS_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (REG_INPUT == 1'b0 && !(host_wr && host_cs1)) |=> $stable(gate_out)) else $error("gate moved w/o cs1"); // R7

endmodule

// File: tb/test_fast_a20_gate.sv
module test_fast_a20_gate;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fast_en = 1'b0;
   logic       host_wr = 1'b0;
   logic       host_cs1 = 1'b0;
   logic       host_is_cmd = 1'b0;
   logic [7:0] host_byte = 8'h00;
   logic       gate_out;
   logic       gate_level;

   int total = 0;
   int bad = 0;
   bit m_armed = 1'b0;
   bit m_gate  = 1'b1;

   always #2 clk = ~clk;

   fast_a20_gate i_fast_a20_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .fast_en    (fast_en),
      .host_wr    (host_wr),
      .host_cs1   (host_cs1),
      .host_is_cmd(host_is_cmd),
      .host_byte  (host_byte),
      .gate_out   (gate_out),
      .gate_level (gate_level)
   );

   function automatic string classify(bit en, bit wr, bit cs, bit cmd, logic [7:0] b, bit armed);
      if (!en)            return "R6";
      if (wr && !cs)      return "R7";
      if (!wr)            return "R9";
      if (cmd && b == 8'hD1) return armed ? "R10" : "R2";
      if (cmd)            return armed ? "R5" : "R9";
      return armed ? "R3" : "R8";
   endfunction

   function automatic bit model_gate(bit en, bit wr, bit cs, bit cmd, logic [7:0] b, bit armed, bit g);
      if (en && wr && cs && !cmd && armed) return b[1];
      return g;
   endfunction

   function automatic bit model_arm(bit en, bit wr, bit cs, bit cmd, logic [7:0] b, bit armed);
      if (!en) return 1'b0;
      if (!(wr && cs)) return armed;
      if (cmd) return (b == 8'hD1);
      return 1'b0;
   endfunction

   task automatic check(string tag);
      total++;
      if (gate_out !== m_gate) begin
         bad++;
         $display("FAIL %s gate_out actual=%b expected=%b", tag, gate_out, m_gate);
      end
      total++;
      if (gate_level !== gate_out) begin
         bad++;
         $display("FAIL R9 gate_level actual=%b expected=%b", gate_level, gate_out);
      end
   endtask

   task automatic step(bit en, bit wr, bit cs, bit cmd, logic [7:0] b, string tag_in = "");
      string tag;
      fast_en = en; host_wr = wr; host_cs1 = cs; host_is_cmd = cmd; host_byte = b;
      tag = (tag_in == "") ? classify(en, wr, cs, cmd, b, m_armed) : tag_in;
      @(posedge clk);
      m_gate  = model_gate(en, wr, cs, cmd, b, m_armed, m_gate);
      m_armed = model_arm(en, wr, cs, cmd, b, m_armed);
      @(negedge clk);
      check(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'h1A20;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      check("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1");
      step(1, 1, 1, 0, 8'h00, "R1");          // data after reset ignored
      // arm then apply 0
      step(1, 1, 1, 1, 8'hD1);                // R2
      step(1, 1, 1, 0, 8'hFD);                // R3 -> 0
      step(1, 1, 1, 0, 8'h02, "R4");          // ignored
      // re-arm, re-arm again, apply 1
      step(1, 1, 1, 1, 8'hD1);
      step(1, 1, 1, 1, 8'hD1);                // R10
      step(1, 1, 1, 0, 8'h02);                // R3 -> 1
      // cancel by other command
      step(1, 1, 1, 1, 8'hD1);
      step(1, 1, 1, 1, 8'hD0);                // R5
      step(1, 1, 1, 0, 8'h00, "R5");          // stays 1
      // wrong channel does not cancel or apply
      step(1, 1, 1, 1, 8'hD1);
      step(1, 1, 0, 0, 8'h00);                // R7
      step(1, 1, 0, 1, 8'h55, "R7");
      step(1, 1, 1, 0, 8'h00, "R7");          // still armed -> 0
      // disable clears arm
      step(1, 1, 1, 1, 8'hD1);
      step(0, 1, 1, 0, 8'h02);                // R6
      step(1, 1, 1, 0, 8'h02, "R6");          // not armed: stays 0
      for (int i = 0; i < 3000; i++) begin
         bit en, wr, cs, cmd;
         logic [7:0] b;
         en  = ($urandom % 8) != 0;
         wr  = ($urandom % 4) != 0;
         cs  = ($urandom % 5) != 0;
         cmd = ($urandom % 2) != 0;
         b   = (($urandom % 3) == 0) ? 8'hD1 : 8'($urandom);
         step(en, wr, cs, cmd, b);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule